// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Monitor

This block compares two single-cycle strobes, both synchronous to the reference clock. One marks each rising edge of the divided reference. The other marks each rising edge of the divided oscillator. From them it produces pump-up and pump-down commands for an external charge pump. When a strobe arrives, the block opens a pulse and holds it until the other strobe arrives. A second strobe of the same kind only prolongs the open pulse, so the detector also steers frequency and not just phase. A polarity input swaps the meaning of the two commands, which suits oscillators and filters whose tuning slope is inverted. A pump-off input silences both commands and raises a flag that tells the analog stage to float its output, which leaves the loop open.

A lock monitor measures each comparison in reference-clock periods. A comparison is good when its pulse lasts less than one period, which at this sampling resolution means the two strobes were coincident. After fifteen consecutive good comparisons the monitor reports lock. A pulse that reaches one period clears the run at once, and the monitor reports unlock. A lock-output enable turns the indicator into a constant high. A chip enable puts the block to sleep: both commands stay idle, strobes are ignored and the run is cleared.

Top module: `pfd_lock_monitor`

## Requirements
- R1: After reset, up and dn are 0 and, with ld_en = 1, lock_out is 0.
- R2: With pol_pos = 1, a lone ref_edge sampled at a clock edge raises up right after that edge. up stays high until the clock edge that samples fb_edge and falls right after it. A lone fb_edge raises dn in the same way. up and dn are never high together.
- R3: With pol_pos = 0, the two commands swap roles: a reference-led pulse appears on dn, and a feedback-led pulse appears on up.
- R4: When ref_edge and fb_edge are sampled at the same clock edge and no pulse is open, neither up nor dn rises.
- R5: A repeated ref_edge while a reference-led pulse is open keeps the pulse high without queueing a second pulse: one fb_edge closes it.
- R6: While pump_off = 1, up and dn are 0 and pump_hiz is 1, and pump_hiz is 0 otherwise. The detector state keeps running underneath, so clearing pump_off during an open pulse shows that pulse at once.
- R7: lock_out (with ld_en = 1) rises right after the clock edge that samples the 15th consecutive good comparison, and not after the 14th.
- R8: A pulse lasting one reference period or more drives lock_out low right after the edge that ends its first period. It also restarts the run, so 15 new good comparisons are needed.
- R9: With ld_en = 0, lock_out is 1 whatever the loop state.
- R10: While chip_en = 0, up and dn are 0, strobes are ignored, the run is cleared and lock_out is 0 when ld_en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle strobe per divided reference edge |
| fb_edge | input | 1 | One-cycle strobe per divided oscillator edge |
| pol_pos | input | 1 | 1 selects positive slope, 0 negative slope |
| pump_off | input | 1 | 1 silences both commands and floats the pump |
| ld_en | input | 1 | 1 lets lock_out report lock state; 0 forces it high |
| chip_en | input | 1 | 0 puts the block to sleep |
| up | output | 1 | Pump-up command |
| dn | output | 1 | Pump-down command |
| pump_hiz | output | 1 | Request to float the charge-pump output |
| lock_out | output | 1 | Lock indicator |

## Verification
The hardest state to reach from the ports is the boundary of the good-comparison run. The run has to stand at exactly fourteen and then fifteen, and a late pulse has to break it after lock. The stimulus first forces a known restart with a long pulse. It then issues counted bursts of coincident strobes and checks the indicator on both sides of the threshold. A randomized phase mixes lone, coincident and repeated strobes with polarity, pump-off, enable and sleep changes, and a behavioural model checks the outputs on every clock.

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor #(
  parameter int LOCK_COUNT = 15,
  parameter int BAD_WIDTH  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic fb_edge,
  input  logic pol_pos,
  input  logic pump_off,
  input  logic ld_en,
  input  logic chip_en,
  output logic up,
  output logic dn,
  output logic pump_hiz,
  output logic lock_out
);
  localparam int GW = $clog2(LOCK_COUNT + 1);
  localparam int WW = $clog2(BAD_WIDTH + 1);
  localparam logic [GW-1:0] FULL = GW'(LOCK_COUNT);
  localparam logic [WW:0]   BADW = (WW+1)'(BAD_WIDTH);

  logic          ref_q, fb_q;
  logic [WW-1:0] wcnt;
  logic [GW-1:0] gcnt;

  logic ref_nx, fb_nx, both, active, long_pulse, good_done, pump_en, locked;
  logic [WW:0] wnext;

  assign ref_nx     = ref_q | ref_edge;
  assign fb_nx      = fb_q | fb_edge;
  assign both       = ref_nx & fb_nx;
  assign active     = ref_q | fb_q;
  assign wnext      = {1'b0, wcnt} + 1'b1;
  assign long_pulse = active && (wnext >= BADW);
  assign good_done  = both && !long_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n || !chip_en) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else if (both) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_nx;
      fb_q  <= fb_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !chip_en || both || !active)
      wcnt <= '0;
    else if (wnext <= BADW)
      wcnt <= wnext[WW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !chip_en || long_pulse)
      gcnt <= '0;
    else if (good_done && gcnt != FULL)
      gcnt <= gcnt + 1'b1;
  end

  assign locked   = chip_en && (gcnt == FULL);
  assign pump_en  = chip_en && !pump_off;
  assign up       = pump_en && (pol_pos ? ref_q : fb_q);
  assign dn       = pump_en && (pol_pos ? fb_q : ref_q);
  assign pump_hiz = pump_off;
  assign lock_out = !ld_en || locked;
endmodule

module pfd_lock_monitor_chk #(
  parameter int LOCK_COUNT = 15,
  parameter int GW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en,
  input logic          ld_en,
  input logic          pump_off,
  input logic          up,
  input logic          dn,
  input logic          pump_hiz,
  input logic          lock_out,
  input logic [GW-1:0] gcnt
);
  a_r6_pump_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pump_off |-> (!up && !dn && pump_hiz));
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));
  a_r9_ld_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |-> lock_out);
  a_r10_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (gcnt == '0 && !up && !dn));
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gcnt != $past(gcnt)) |-> (gcnt == '0 || gcnt == $past(gcnt) + 1'b1));
  a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gcnt) <= LOCK_COUNT);
endmodule

bind pfd_lock_monitor pfd_lock_monitor_chk #(.LOCK_COUNT(LOCK_COUNT), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ld_en(ld_en), .pump_off(pump_off),
  .up(up), .dn(dn), .pump_hiz(pump_hiz), .lock_out(lock_out), .gcnt(gcnt)
);

// File: tb/tb_pfd_lock_monitor.sv
module tb_pfd_lock_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 15;

  logic clk = 0, rst_n = 0;
  logic ref_edge = 0, fb_edge = 0, pol_pos = 1, pump_off = 0, ld_en = 1, chip_en = 1;
  logic up, dn, pump_hiz, lock_out;
  int compared = 0, mismatched = 0;
  int lead = 0, width = 0, good = 0;

  pfd_lock_monitor dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .pol_pos(pol_pos), .pump_off(pump_off), .ld_en(ld_en), .chip_en(chip_en),
    .up(up), .dn(dn), .pump_hiz(pump_hiz), .lock_out(lock_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: lead +1 = reference pending, -1 = feedback pending
  always @(posedge clk) begin
    if (!rst_n || !chip_en) begin
      lead = 0; width = 0; good = 0;
    end else begin
      bit resolved, bad;
      bad = (lead != 0) && (width + 1 >= 1);
      resolved = (lead == 1 && fb_edge) || (lead == -1 && ref_edge) ||
                 (lead == 0 && ref_edge && fb_edge);
      if (bad) good = 0;
      else if (resolved && good < RUN) good++;
      if (resolved) begin lead = 0; width = 0; end
      else if (lead == 0) begin lead = ref_edge ? 1 : (fb_edge ? -1 : 0); width = 0; end
      else width++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit en;
    en = chip_en && !pump_off;
    chk("R2/R3 model up", up, en && (pol_pos ? lead == 1 : lead == -1));
    chk("R2/R3 model dn", dn, en && (pol_pos ? lead == -1 : lead == 1));
    chk("R6 model hiz", pump_hiz, pump_off);
    chk("R7/R9 model lock", lock_out, !ld_en || (chip_en && good == RUN));
  end

  task automatic cyc(input logic r, input logic f);
    ref_edge = r; fb_edge = f;
    @(posedge clk); #1;
    ref_edge = 0; fb_edge = 0;
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) begin cyc(1, 1); cyc(0, 0); end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 up", up, 0); chk("R1 dn", dn, 0); chk("R1 lock", lock_out, 0);
    rst_n = 1;
    cyc(0, 0);
    // R2
    cyc(1, 0); chk("R2 up rises", up, 1); chk("R2 dn idle", dn, 0);
    cyc(0, 0); chk("R2 up held", up, 1);
    cyc(0, 1); chk("R2 up falls", up, 0); chk("R2 dn stays", dn, 0);
    cyc(0, 1); chk("R2 dn rises", dn, 1);
    cyc(1, 0); chk("R2 dn falls", dn, 0);
    // R3
    pol_pos = 0;
    cyc(1, 0); chk("R3 ref-led on dn", dn, 1); chk("R3 up idle", up, 0);
    cyc(0, 1);
    cyc(0, 1); chk("R3 fb-led on up", up, 1);
    cyc(1, 0);
    pol_pos = 1;
    // R4
    cyc(1, 1); chk("R4 no up", up, 0); chk("R4 no dn", dn, 0);
    // R5
    cyc(1, 0); cyc(1, 0); chk("R5 up held", up, 1);
    cyc(0, 1); chk("R5 closed", up, 0);
    cyc(0, 0); chk("R5 no second up", up, 0); chk("R5 no dn", dn, 0);
    // R7
    cyc(1, 0); cyc(0, 1);
    goods(RUN - 1); chk("R7 not at 14", lock_out, 0);
    goods(1); chk("R7 at 15", lock_out, 1);
    // R8
    cyc(1, 0); chk("R8 still locked", lock_out, 1);
    cyc(0, 1); chk("R8 dropped", lock_out, 0);
    goods(RUN - 1); chk("R8 restart 14", lock_out, 0);
    goods(1); chk("R8 restart 15", lock_out, 1);
    // R6
    pump_off = 1;
    cyc(1, 0); chk("R6 up silent", up, 0); chk("R6 hiz", pump_hiz, 1);
    pump_off = 0; #1;
    chk("R6 up resumes", up, 1); chk("R6 hiz clear", pump_hiz, 0);
    cyc(0, 1);
    // R9
    ld_en = 0; #1; chk("R9 forced", lock_out, 1);
    cyc(1, 0); cyc(0, 1); chk("R9 forced after bad", lock_out, 1);
    ld_en = 1; #1; chk("R9 real state", lock_out, 0);
    // R10
    goods(RUN); chk("R10 locked first", lock_out, 1);
    chip_en = 0; #1; chk("R10 sleep unlock", lock_out, 0);
    cyc(1, 0); chk("R10 strobe ignored", up, 0);
    chip_en = 1; #1; chk("R10 wake up idle", up, 0); chk("R10 wake unlocked", lock_out, 0);
    cyc(0, 0); chk("R10 still idle", up, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 3) pol_pos = ~pol_pos;
      else if (k < 5) pump_off = ~pump_off;
      else if (k < 7) ld_en = ~ld_en;
      else if (k < 8) chip_en = ~chip_en;
      k = $urandom_range(0, 9);
      if (k < 4) cyc(1, 1);
      else if (k == 4) cyc(1, 0);
      else if (k == 5) cyc(0, 1);
      else cyc(0, 0);
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule